// File: doc/BRIEF.md
# Conditional Microoperation Datapath

This block is a small register-transfer datapath. It holds three working registers of parameterised width. In each cycle an operation code picks one whole-word microoperation. Two 2-bit indices choose the operands, and a third 2-bit index chooses the register that receives the result. The result is written only when a Boolean control expression is true. That expression is the OR of two control inputs, so a transfer can be guarded by a condition such as "P or Q". A register that is not written takes its own output back on every edge and keeps its value while the clock runs.

Addition, subtraction, two's complement, increment and decrement all share one adder. Subtraction feeds the inverted second operand into the adder with a carry-in of one. The operation code is the only control variable that turns an add into a subtract. A parallel load port writes any register directly, so test code can set up operands. A synchronous reset clears every register.

Top module: `uop_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, all three registers become 0 after that edge, whatever the other inputs are.
- R2: When `ld_en` is 0 and both `cond_a` and `cond_b` are 0, no register changes at the edge.
- R3: When `ld_en` is 0 and `cond_a` OR `cond_b` is 1, only the register chosen by `dst` (0, 1 or 2) takes the result. The other two keep their values.
- R4: A `dst` value of 3 writes no register.
- R5: Code 0 writes A + B modulo 2^W. The carry is dropped.
- R6: Code 1 writes A + ~B + 1 modulo 2^W, which is A minus B. With A taken from register 2 and B from register 1, this gives R2 minus R1.
- R7: Code 2 writes ~A (ones' complement, the same as bitwise NOT). Code 3 writes ~A + 1 modulo 2^W, so the two's complement of 0 is 0.
- R8: Code 4 writes A + 1 and code 5 writes A − 1. Both wrap modulo 2^W.
- R9: Code 6 writes A | B, code 7 writes A & B and code 8 writes A ^ B.
- R10: Code 9 writes A shifted left by one bit and code 10 writes A shifted right by one bit. The vacated bit is 0 and the bit shifted out is lost.
- R11: Codes 11 to 15 write no register.
- R12: When `ld_en` is 1, `ld_val` is written into the register chosen by `ld_idx` (3 selects none). The microoperation of that cycle is suppressed, whatever the conditions are.
- R13: A source index of 3 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ld_en | input | 1 | Parallel load request |
| ld_idx | input | 2 | Register chosen for the parallel load |
| ld_val | input | W | Parallel load data |
| cond_a | input | 1 | First term of the control expression |
| cond_b | input | 1 | Second term of the control expression |
| op | input | 4 | Microoperation code |
| src_a | input | 2 | Index of operand A |
| src_b | input | 2 | Index of operand B |
| dst | input | 2 | Index of the destination register |
| r0 | output | W | Register 0 contents |
| r1 | output | W | Register 1 contents |
| r2 | output | W | Register 2 contents |

## Verification
Every result is due exactly one clock edge after its inputs are presented. The read path and the operation are combinational, and the register outputs are the ports. A load, a microoperation and a reset each show on `r0`..`r2` after the next rising edge. The bench changes inputs on the falling edge and samples all three registers on the following falling edge. Each check therefore sees the state one edge after the stimulus, and the unselected registers are compared in the same sample.

// File: rtl/uop_pkg.sv
package uop_pkg;
    localparam int NREG = 3;
    localparam int IDXW = 2;
    localparam int OPW  = 4;

    typedef enum logic [OPW-1:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_NOT  = 4'd2,
        OP_NEG  = 4'd3,
        OP_INC  = 4'd4,
        OP_DEC  = 4'd5,
        OP_OR   = 4'd6,
        OP_AND  = 4'd7,
        OP_XOR  = 4'd8,
        OP_SHL  = 4'd9,
        OP_SHR  = 4'd10
    } uop_e;
endpackage

// File: rtl/uop_addsub.sv
module uop_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         inv_y,
    input  logic         cin,
    output logic [W-1:0] sum
);
    localparam logic [W-1:0] ZERO = '0;

    logic [W-1:0] y_eff;
    logic [W-1:0] cin_w;

    assign y_eff = inv_y ? ~y : y;
    assign cin_w = {ZERO[W-1:1], cin};
    assign sum   = x + y_eff + cin_w;
endmodule

// File: rtl/uop_alu.sv
module uop_alu
    import uop_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [OPW-1:0] op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   res,
    output logic           writes
);
    logic [W-1:0] ax;
    logic [W-1:0] ay;
    logic         inv;
    logic         cin;
    logic         use_sum;
    logic [W-1:0] sum;
    logic [W-1:0] logic_res;

    uop_addsub #(.W(W)) u_add (
        .x     (ax),
        .y     (ay),
        .inv_y (inv),
        .cin   (cin),
        .sum   (sum)
    );

    always_comb begin
        ax        = a;
        ay        = b;
        inv       = 1'b0;
        cin       = 1'b0;
        use_sum   = 1'b1;
        logic_res = '0;
        writes    = 1'b1;
        unique case (op)
            OP_ADD: ;
            OP_SUB: begin
                inv = 1'b1;
                cin = 1'b1;
            end
            OP_NEG: begin
                ax  = '0;
                ay  = a;
                inv = 1'b1;
                cin = 1'b1;
            end
            OP_INC: begin
                ay  = '0;
                cin = 1'b1;
            end
            OP_DEC: begin
                ay  = '0;
                inv = 1'b1;
            end
            OP_NOT: begin
                use_sum   = 1'b0;
                logic_res = ~a;
            end
            OP_OR: begin
                use_sum   = 1'b0;
                logic_res = a | b;
            end
            OP_AND: begin
                use_sum   = 1'b0;
                logic_res = a & b;
            end
            OP_XOR: begin
                use_sum   = 1'b0;
                logic_res = a ^ b;
            end
            OP_SHL: begin
                use_sum   = 1'b0;
                logic_res = {a[W-2:0], 1'b0};
            end
            OP_SHR: begin
                use_sum   = 1'b0;
                logic_res = {1'b0, a[W-1:1]};
            end
            default: begin
                use_sum = 1'b0;
                writes  = 1'b0;
            end
        endcase
        res = use_sum ? sum : logic_res;
    end
endmodule

// File: rtl/uop_regbank.sv
module uop_regbank
    import uop_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NREG-1:0]           ld_hit,
    input  logic [W-1:0]              ld_val,
    input  logic [NREG-1:0]           wr_hit,
    input  logic [W-1:0]              wr_val,
    output logic [NREG-1:0][W-1:0]    q
);
    for (genvar i = 0; i < NREG; i++) begin : g_reg
        logic [W-1:0] d;

        always_comb begin
            if (ld_hit[i])      d = ld_val;
            else if (wr_hit[i]) d = wr_val;
            else                d = q[i];
        end

        always_ff @(posedge clk) begin
            if (rst) q[i] <= '0;
            else     q[i] <= d;
        end
    end
endmodule

// File: rtl/uop_unit.sv
module uop_unit
    import uop_pkg::*;
#(
    parameter int W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_en,
    input  logic [1:0]       ld_idx,
    input  logic [W-1:0]     ld_val,
    input  logic             cond_a,
    input  logic             cond_b,
    input  logic [3:0]       op,
    input  logic [1:0]       src_a,
    input  logic [1:0]       src_b,
    input  logic [1:0]       dst,
    output logic [W-1:0]     r0,
    output logic [W-1:0]     r1,
    output logic [W-1:0]     r2
);
    logic [NREG-1:0][W-1:0] q;
    logic [W-1:0]           opa;
    logic [W-1:0]           opb;
    logic [W-1:0]           res;
    logic                   writes;
    logic                   fire;
    logic [NREG-1:0]        ld_hit;
    logic [NREG-1:0]        wr_hit;

    function automatic logic [W-1:0] pick(input logic [1:0] idx,
                                          input logic [NREG-1:0][W-1:0] regs);
        case (idx)
            2'd0:    pick = regs[0];
            2'd1:    pick = regs[1];
            2'd2:    pick = regs[2];
            default: pick = '0;
        endcase
    endfunction

    assign opa  = pick(src_a, q);
    assign opb  = pick(src_b, q);
    assign fire = cond_a | cond_b;

    uop_alu #(.W(W)) u_alu (
        .op     (op),
        .a      (opa),
        .b      (opb),
        .res    (res),
        .writes (writes)
    );

    for (genvar i = 0; i < NREG; i++) begin : g_dec
        assign ld_hit[i] = ld_en && (ld_idx == IDXW'(i));
        assign wr_hit[i] = !ld_en && fire && writes && (dst == IDXW'(i));
    end

    uop_regbank #(.W(W)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .ld_hit (ld_hit),
        .ld_val (ld_val),
        .wr_hit (wr_hit),
        .wr_val (res),
        .q      (q)
    );

    assign r0 = q[0];
    assign r1 = q[1];
    assign r2 = q[2];
endmodule

// File: rtl/uop_unit_chk.sv
module uop_unit_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         ld_en,
    input logic [1:0]   ld_idx,
    input logic [W-1:0] ld_val,
    input logic         cond_a,
    input logic         cond_b,
    input logic [3:0]   op,
    input logic [1:0]   src_a,
    input logic [1:0]   dst,
    input logic [W-1:0] r0,
    input logic [W-1:0] r1,
    input logic [W-1:0] r2
);
    localparam logic [W-1:0] ONE = W'(1);

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (r0 == '0 && r1 == '0 && r2 == '0));

    assert_hold_no_cond_R2: assert property (@(posedge clk) disable iff (rst)
        (!ld_en && !cond_a && !cond_b) |=> ($stable(r0) && $stable(r1) && $stable(r2)));

    assert_only_dst_R3: assert property (@(posedge clk) disable iff (rst)
        (!ld_en && (cond_a || cond_b) && dst == 2'd0) |=> ($stable(r1) && $stable(r2)));

    assert_dst3_idle_R4: assert property (@(posedge clk) disable iff (rst)
        (!ld_en && dst == 2'd3) |=> ($stable(r0) && $stable(r1) && $stable(r2)));

    assert_inc_wraps_R8: assert property (@(posedge clk) disable iff (rst)
        (!ld_en && (cond_a || cond_b) && op == 4'd4 && src_a == 2'd0 && dst == 2'd0)
        |=> (r0 == $past(r0) + ONE));

    assert_spare_codes_R11: assert property (@(posedge clk) disable iff (rst)
        (!ld_en && op >= 4'd11) |=> ($stable(r0) && $stable(r1) && $stable(r2)));

    assert_load_lands_R12: assert property (@(posedge clk) disable iff (rst)
        (ld_en && ld_idx == 2'd1) |=> (r1 == $past(ld_val) && $stable(r0) && $stable(r2)));
endmodule

bind uop_unit uop_unit_chk #(.W(W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .ld_en  (ld_en),
    .ld_idx (ld_idx),
    .ld_val (ld_val),
    .cond_a (cond_a),
    .cond_b (cond_b),
    .op     (op),
    .src_a  (src_a),
    .dst    (dst),
    .r0     (r0),
    .r1     (r1),
    .r2     (r2)
);

// File: tb/tb_uop_unit.sv
module tb_uop_unit;
    localparam int W = 8;
    localparam int NV = 22;

    // entry: op, src_a, src_b, dst, cond_a, cond_b, pre r0 r1 r2, exp r0 r1 r2
    localparam logic [59:0] VEC [NV] = '{
        {4'd0, 2'd1, 2'd2, 2'd0, 1'b1, 1'b0, 8'h00, 8'h30, 8'h25, 8'h55, 8'h30, 8'h25},
        {4'd0, 2'd1, 2'd2, 2'd0, 1'b0, 1'b1, 8'h00, 8'hF0, 8'h20, 8'h10, 8'hF0, 8'h20},
        {4'd1, 2'd1, 2'd2, 2'd0, 1'b1, 1'b1, 8'h00, 8'h50, 8'h20, 8'h30, 8'h50, 8'h20},
        {4'd1, 2'd1, 2'd2, 2'd0, 1'b1, 1'b0, 8'h00, 8'h10, 8'h20, 8'hF0, 8'h10, 8'h20},
        {4'd1, 2'd2, 2'd1, 2'd0, 1'b1, 1'b0, 8'h00, 8'h05, 8'h09, 8'h04, 8'h05, 8'h09},
        {4'd2, 2'd1, 2'd0, 2'd2, 1'b1, 1'b0, 8'h00, 8'h5A, 8'h00, 8'h00, 8'h5A, 8'hA5},
        {4'd3, 2'd1, 2'd0, 2'd0, 1'b1, 1'b0, 8'h00, 8'h01, 8'h00, 8'hFF, 8'h01, 8'h00},
        {4'd3, 2'd0, 2'd0, 2'd1, 1'b0, 1'b1, 8'h00, 8'h77, 8'h00, 8'h00, 8'h00, 8'h00},
        {4'd4, 2'd0, 2'd0, 2'd0, 1'b1, 1'b0, 8'hFF, 8'h01, 8'h02, 8'h00, 8'h01, 8'h02},
        {4'd4, 2'd0, 2'd0, 2'd0, 1'b1, 1'b0, 8'h7F, 8'h01, 8'h02, 8'h80, 8'h01, 8'h02},
        {4'd5, 2'd2, 2'd0, 2'd2, 1'b1, 1'b0, 8'h11, 8'h22, 8'h00, 8'h11, 8'h22, 8'hFF},
        {4'd6, 2'd0, 2'd1, 2'd0, 1'b1, 1'b0, 8'hC3, 8'h0C, 8'h00, 8'hCF, 8'h0C, 8'h00},
        {4'd7, 2'd0, 2'd1, 2'd0, 1'b1, 1'b0, 8'hC3, 8'h0F, 8'h00, 8'h03, 8'h0F, 8'h00},
        {4'd8, 2'd0, 2'd1, 2'd0, 1'b1, 1'b0, 8'hC3, 8'hFF, 8'h00, 8'h3C, 8'hFF, 8'h00},
        {4'd9, 2'd1, 2'd0, 2'd1, 1'b1, 1'b0, 8'h00, 8'h81, 8'h00, 8'h00, 8'h02, 8'h00},
        {4'd10, 2'd1, 2'd0, 2'd1, 1'b1, 1'b0, 8'h00, 8'h81, 8'h00, 8'h00, 8'h40, 8'h00},
        {4'd0, 2'd1, 2'd2, 2'd0, 1'b0, 1'b0, 8'h11, 8'h22, 8'h33, 8'h11, 8'h22, 8'h33},
        {4'd0, 2'd1, 2'd2, 2'd3, 1'b1, 1'b1, 8'h11, 8'h22, 8'h33, 8'h11, 8'h22, 8'h33},
        {4'd12, 2'd1, 2'd2, 2'd0, 1'b1, 1'b0, 8'h11, 8'h22, 8'h33, 8'h11, 8'h22, 8'h33},
        {4'd15, 2'd1, 2'd2, 2'd2, 1'b0, 1'b1, 8'h11, 8'h22, 8'h33, 8'h11, 8'h22, 8'h33},
        {4'd0, 2'd3, 2'd2, 2'd0, 1'b1, 1'b0, 8'h99, 8'h00, 8'h07, 8'h07, 8'h00, 8'h07},
        {4'd8, 2'd2, 2'd3, 2'd1, 1'b1, 1'b0, 8'h00, 8'h66, 8'h5A, 8'h00, 8'h5A, 8'h5A}
    };

    logic         clk = 1'b0;
    logic         rst;
    logic         ld_en;
    logic [1:0]   ld_idx;
    logic [W-1:0] ld_val;
    logic         cond_a;
    logic         cond_b;
    logic [3:0]   op;
    logic [1:0]   src_a;
    logic [1:0]   src_b;
    logic [1:0]   dst;
    logic [W-1:0] r0;
    logic [W-1:0] r1;
    logic [W-1:0] r2;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    uop_unit #(.W(W)) dut (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_idx(ld_idx), .ld_val(ld_val),
        .cond_a(cond_a), .cond_b(cond_b), .op(op), .src_a(src_a), .src_b(src_b),
        .dst(dst), .r0(r0), .r1(r1), .r2(r2)
    );

    task automatic check(input string req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req, input logic [W-1:0] e0,
                             input logic [W-1:0] e1, input logic [W-1:0] e2);
        check(req, "r0", r0, e0);
        check(req, "r1", r1, e1);
        check(req, "r2", r2, e2);
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        ld_en = 1'b0; cond_a = 1'b0; cond_b = 1'b0;
        op = 4'd0; src_a = 2'd0; src_b = 2'd0; dst = 2'd3;
    endtask

    task automatic load(input logic [1:0] idx, input logic [W-1:0] v);
        idle();
        ld_en = 1'b1; ld_idx = idx; ld_val = v;
        tick();
        ld_en = 1'b0;
    endtask

    function automatic string tag_of(input logic [59:0] e);
        logic [3:0] o;
        o = e[59:56];
        if (e[51:50] == 2'b00)  return "R2";
        if (e[53:52] == 2'd3)   return "R4";
        if (e[57:56] != 2'd0 && o == 4'd0 && e[55:54] == 2'd3) return "R13";
        if (e[55:54] == 2'd3)   return "R13";
        if (e[53:52] == 2'd3)   return "R13";
        case (o)
            4'd0:          return "R5/R3";
            4'd1:          return "R6/R3";
            4'd2, 4'd3:    return "R7/R3";
            4'd4, 4'd5:    return "R8/R3";
            4'd6, 4'd7, 4'd8: return "R9/R3";
            4'd9, 4'd10:   return "R10/R3";
            default:       return "R11";
        endcase
    endfunction

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; ld_idx = 2'd0; ld_val = '0;
        idle();
        tick();
        tick();
        check_all("R1", 8'h00, 8'h00, 8'h00);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            logic [59:0] e;
            e = VEC[i];
            load(2'd0, e[47:40]);
            load(2'd1, e[39:32]);
            load(2'd2, e[31:24]);
            op = e[59:56]; src_a = e[55:54]; src_b = e[53:52];
            dst = e[51:50]; cond_a = e[49]; cond_b = e[48];
            tick();
            idle();
            check_all(tag_of(e), e[23:16], e[15:8], e[7:0]);
        end

        // R12: load beats a live microoperation aimed at another register
        load(2'd0, 8'h10);
        load(2'd1, 8'h20);
        load(2'd2, 8'h30);
        ld_en = 1'b1; ld_idx = 2'd1; ld_val = 8'hAB;
        op = 4'd4; src_a = 2'd0; dst = 2'd0; cond_a = 1'b1;
        tick();
        idle();
        check_all("R12", 8'h10, 8'hAB, 8'h30);

        // R12: load index 3 writes nothing, op suppressed too
        ld_en = 1'b1; ld_idx = 2'd3; ld_val = 8'hEE;
        op = 4'd0; src_a = 2'd0; src_b = 2'd1; dst = 2'd2; cond_b = 1'b1;
        tick();
        idle();
        check_all("R12", 8'h10, 8'hAB, 8'h30);

        // R8: back-to-back decrements chain one edge apart
        op = 4'd5; src_a = 2'd0; dst = 2'd0; cond_a = 1'b1;
        tick();
        check("R8", "r0 dec1", r0, 8'h0F);
        tick();
        idle();
        check("R8", "r0 dec2", r0, 8'h0E);

        // R1: reset wins over a live operation and a load
        rst = 1'b1; ld_en = 1'b1; ld_idx = 2'd2; ld_val = 8'h77;
        tick();
        rst = 1'b0;
        idle();
        check_all("R1", 8'h00, 8'h00, 8'h00);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule